// File: doc/BRIEF.md
# Multi-lane Link Transmit Phase Sequencer

This block steps the transmit side of a multi-lane serial converter link through three phases: code-group synchronization, the four-multiframe initial lane alignment sequence, and user data. A receiver holds an active-low synchronization request while it needs comma characters. Once that request is released, the sequencer waits for the next multiframe boundary, sends the alignment sequence, and then passes user words through. Every lane carries a 32-bit word per link clock, which holds four octets, together with a flag for each byte that marks a control character. Encoding, scrambling and serialization happen after this block.

The multiframe length in octets is the product of two run-time inputs: octets per frame (8 bits) and frames per multiframe (5 bits). This product must be a non-zero multiple of four, so that every multiframe starts on octet 0 of a word. The data input uses a valid/ready handshake with zero ready latency and does not back-pressure: a word presented while `link_ready` is high is consumed in that same cycle. The producer must keep data flowing every cycle while ready is high, and a word with `in_valid` low is not waited for. `frame_ready` tells the upstream transport stage one multiframe in advance that the data phase is about to begin.

Top module: `txseq_link_tx`

## Requirements
- R1: During reset every lane outputs 0xBC on all four octets with all control flags set, both ready outputs are low and `err_sticky` is 0.
- R2: While `sync_req_n` is low, or while the block is in the synchronization phase, the next output word of every lane is 0xBC on all octets with all four control flags set.
- R3: The word counter starts at 0 on the first clock after reset and wraps after (octets per frame × frames per multiframe)/4 words. Alignment begins on the first word of the first multiframe that starts after a cycle in which `sync_req_n` is high. It lasts exactly four multiframes, and the data phase follows.
- R4: In alignment, octet index o (0 at the first octet of the multiframe) is output as follows: o = 0 sends 0x1C; the last octet sends 0x7C; o = 1 in the second alignment multiframe sends 0x9C (all three with the control flag set); every other octet sends o modulo 256 with the flag clear. Octet 0 of a word sits in bits [31:24] and its flag in bit 3.
- R5: `mf_start[3]` is high in the cycles where the word counter is 0, and `mf_start[2:0]` is always 0.
- R6: `link_ready` is high exactly while the block is in the data phase and `sync_req_n` is high. A word accepted with `in_valid` high and `in_err` low appears one cycle later unchanged on `lane_data`, with control flags clear. Lane n occupies bits [32n+31:32n] of both buses.
- R7: `frame_ready` is high during the fourth alignment multiframe and during the data phase, in both cases only while `sync_req_n` is high.
- R8: When `sync_req_n` goes low during alignment or data, both ready outputs fall in that same cycle, and the block restarts from the synchronization phase.
- R9: An accepted word with `in_err` high is output on every octet of every lane as the filler 0xE7 with control flags clear, and it sets `err_sticky`, which stays high until reset.
- R10: An accepted word with `in_valid` low and `in_err` low is output as filler and leaves `err_sticky` unchanged.
- R11: `in_err` while `link_ready` is low has no effect on `err_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_req_n | input | 1 | Synchronization request from the receiver, active low |
| in_data | input | LANES*32 | Per-lane user words, lane 0 in the low 32 bits |
| in_valid | input | 1 | Input word is valid |
| in_err | input | 1 | Input word is in error |
| frame_octets | input | 8 | Octets per frame |
| mf_frames | input | 5 | Frames per multiframe |
| link_ready | output | 1 | Data input is accepted this cycle |
| frame_ready | output | 1 | Transport stage may start producing |
| mf_start | output | 4 | Start-of-multiframe marker per octet position |
| lane_data | output | LANES*32 | Per-lane output words |
| lane_ctrl | output | LANES*4 | Per-byte control-character flags |
| err_sticky | output | 1 | Sticky input error flag |

## Verification
Two functions can fall in the same cycle. First, a synchronization request can drop in the very cycle that a word flagged as erroneous is presented. In that cycle ready has already fallen, so the bench expects comma characters, not filler, on the next output, and expects `err_sticky` to stay clear. Second, the release of the request can land on the last word of a multiframe. With one word per multiframe this happens on every cycle, so the bench expects alignment to start on the very next word. A reference model in the bench tracks the phase, the word index and the multiframe count, and compares every output in every cycle across five frame configurations.

// File: rtl/txseq_pkg.sv
package txseq_pkg;
  localparam int OCT_W    = 8;               // octets-per-frame field
  localparam int FRM_W    = 5;               // frames-per-multiframe field
  localparam int MFO_W    = OCT_W + FRM_W;   // octets per multiframe
  localparam int ILAS_MFS = 4;               // alignment multiframes
  localparam int MFC_W    = $clog2(ILAS_MFS);
  localparam int BPW      = 4;               // octets per lane word

  typedef enum logic [1:0] {
    PH_CGS  = 2'd0,
    PH_ILAS = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  localparam logic [7:0] K_COMMA    = 8'hBC;
  localparam logic [7:0] K_MF_START = 8'h1C;
  localparam logic [7:0] K_MF_ALIGN = 8'h7C;
  localparam logic [7:0] K_CFG_MARK = 8'h9C;
endpackage

// File: rtl/txseq_mf_timer.sv
module txseq_mf_timer
  import txseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCT_W-1:0] frame_octets,
  input  logic [FRM_W-1:0] mf_frames,
  output logic [MFO_W-1:0] word_idx,
  output logic [MFO_W-1:0] mf_octets,
  output logic             first_w,
  output logic             last_w
);
  logic [MFO_W-1:0] words;

  assign mf_octets = MFO_W'(frame_octets) * MFO_W'(mf_frames);
  assign words     = mf_octets >> 2;
  assign first_w   = (word_idx == '0);
  // tolerate a run-time shrink of the multiframe: wrap at or beyond the end
  assign last_w    = (words <= MFO_W'(1)) || (word_idx >= words - MFO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_idx <= '0;
    else if (last_w) word_idx <= '0;
    else             word_idx <= word_idx + MFO_W'(1);
  end
endmodule

// File: rtl/txseq_phase_ctl.sv
module txseq_phase_ctl
  import txseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_req_n,
  input  logic             first_w,
  input  logic             last_w,
  output phase_e           phase,
  output logic [MFC_W-1:0] mf_num,
  output logic             link_ready,
  output logic             frame_ready
);
  localparam logic [MFC_W-1:0] LAST_MF = MFC_W'(ILAS_MFS - 1);

  assign link_ready  = sync_req_n && (phase == PH_DATA);
  assign frame_ready = sync_req_n &&
                       ((phase == PH_DATA) || (phase == PH_ILAS && mf_num == LAST_MF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_CGS;
      mf_num <= '0;
    end else if (!sync_req_n) begin
      phase  <= PH_CGS;
      mf_num <= '0;
    end else begin
      unique case (phase)
        PH_CGS: if (last_w) begin
          phase  <= PH_ILAS;
          mf_num <= '0;
        end
        PH_ILAS: if (last_w) begin
          if (mf_num == LAST_MF) phase <= PH_DATA;
          else                   mf_num <= mf_num + MFC_W'(1);
        end
        default: phase <= PH_DATA;
      endcase
    end
  end

  // R6
  rdy_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_ready |-> frame_ready);
  // R3
  ilas_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ILAS && $past(phase) == PH_CGS) |-> first_w);
  // R3
  data_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && $past(phase) == PH_ILAS) |-> ($past(last_w) && $past(mf_num) == LAST_MF));
  // R8
  sync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_req_n |=> (phase == PH_CGS && mf_num == '0));
endmodule

// File: rtl/txseq_lane_fmt.sv
module txseq_lane_fmt
  import txseq_pkg::*;
#(
  parameter logic [7:0] FILL_OCTET = 8'hE7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_req_n,
  input  phase_e           phase,
  input  logic [MFC_W-1:0] mf_num,
  input  logic [MFO_W-1:0] word_idx,
  input  logic [MFO_W-1:0] mf_octets,
  input  logic             take,
  input  logic [8*BPW-1:0] in_word,
  output logic [8*BPW-1:0] out_word,
  output logic [BPW-1:0]   out_ctrl
);
  logic [8*BPW-1:0] nxt_word;
  logic [BPW-1:0]   nxt_ctrl;
  logic [MFO_W-1:0] oct_idx;

  always_comb begin
    nxt_word = '0;
    nxt_ctrl = '0;
    oct_idx  = '0;
    for (int j = 0; j < BPW; j++) begin
      oct_idx = (word_idx << 2) + MFO_W'(j);
      if (!sync_req_n || phase == PH_CGS) begin
        nxt_word[8*(BPW-1-j) +: 8] = K_COMMA;
        nxt_ctrl[BPW-1-j]          = 1'b1;
      end else if (phase == PH_ILAS) begin
        if (oct_idx == '0) begin
          nxt_word[8*(BPW-1-j) +: 8] = K_MF_START;
          nxt_ctrl[BPW-1-j]          = 1'b1;
        end else if (oct_idx == mf_octets - MFO_W'(1)) begin
          nxt_word[8*(BPW-1-j) +: 8] = K_MF_ALIGN;
          nxt_ctrl[BPW-1-j]          = 1'b1;
        end else if (mf_num == MFC_W'(1) && oct_idx == MFO_W'(1)) begin
          nxt_word[8*(BPW-1-j) +: 8] = K_CFG_MARK;
          nxt_ctrl[BPW-1-j]          = 1'b1;
        end else begin
          nxt_word[8*(BPW-1-j) +: 8] = oct_idx[7:0];
        end
      end else if (take) begin
        nxt_word[8*(BPW-1-j) +: 8] = in_word[8*(BPW-1-j) +: 8];
      end else begin
        nxt_word[8*(BPW-1-j) +: 8] = FILL_OCTET;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_word <= {BPW{K_COMMA}};
      out_ctrl <= '1;
    end else begin
      out_word <= nxt_word;
      out_ctrl <= nxt_ctrl;
    end
  end

  // R2
  cgs_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_req_n |=> (out_ctrl == '1 && out_word == {BPW{K_COMMA}}));
endmodule

// File: rtl/txseq_link_tx.sv
module txseq_link_tx
  import txseq_pkg::*;
#(
  parameter int         LANES      = 2,
  parameter logic [7:0] FILL_OCTET = 8'hE7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sync_req_n,
  input  logic [LANES*32-1:0]    in_data,
  input  logic                   in_valid,
  input  logic                   in_err,
  input  logic [7:0]             frame_octets,
  input  logic [4:0]             mf_frames,
  output logic                   link_ready,
  output logic                   frame_ready,
  output logic [3:0]             mf_start,
  output logic [LANES*32-1:0]    lane_data,
  output logic [LANES*4-1:0]     lane_ctrl,
  output logic                   err_sticky
);
  localparam int LW = 8 * BPW;

  logic [MFO_W-1:0] word_idx, mf_octets;
  logic             first_w, last_w;
  phase_e           phase;
  logic [MFC_W-1:0] mf_num;
  logic             take;

  txseq_mf_timer u_timer (
    .clk(clk), .rst_n(rst_n), .frame_octets(frame_octets), .mf_frames(mf_frames),
    .word_idx(word_idx), .mf_octets(mf_octets), .first_w(first_w), .last_w(last_w)
  );

  txseq_phase_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .sync_req_n(sync_req_n), .first_w(first_w),
    .last_w(last_w), .phase(phase), .mf_num(mf_num),
    .link_ready(link_ready), .frame_ready(frame_ready)
  );

  assign mf_start = {first_w, 3'b000};
  assign take     = link_ready && in_valid && !in_err;

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    txseq_lane_fmt #(.FILL_OCTET(FILL_OCTET)) u_fmt (
      .clk(clk), .rst_n(rst_n), .sync_req_n(sync_req_n), .phase(phase),
      .mf_num(mf_num), .word_idx(word_idx), .mf_octets(mf_octets), .take(take),
      .in_word(in_data[LW*n +: LW]),
      .out_word(lane_data[LW*n +: LW]),
      .out_ctrl(lane_ctrl[BPW*n +: BPW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     err_sticky <= 1'b0;
    else if (link_ready && in_err)  err_sticky <= 1'b1;
  end

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_sticky) |-> err_sticky);
  // R11
  sticky_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_ready && !err_sticky) |=> !err_sticky);
  // R10
  sticky_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ready && !in_err) |=> (err_sticky == $past(err_sticky)));
endmodule

// File: tb/txseq_link_tx_tb.sv
`timescale 1ns/1ps
module txseq_link_tx_tb;
  localparam int LANES = 2;
  localparam logic [7:0] FILL = 8'hE7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_req_n = 1'b0;
  logic [LANES*32-1:0] in_data = '0;
  logic in_valid = 1'b0, in_err = 1'b0;
  logic [7:0] frame_octets = 8'd1;
  logic [4:0] mf_frames = 5'd4;
  logic link_ready, frame_ready, err_sticky;
  logic [3:0] mf_start;
  logic [LANES*32-1:0] lane_data;
  logic [LANES*4-1:0] lane_ctrl;

  always #4 clk = ~clk;

  txseq_link_tx #(.LANES(LANES), .FILL_OCTET(FILL)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_req_n(sync_req_n), .in_data(in_data),
    .in_valid(in_valid), .in_err(in_err), .frame_octets(frame_octets),
    .mf_frames(mf_frames), .link_ready(link_ready), .frame_ready(frame_ready),
    .mf_start(mf_start), .lane_data(lane_data), .lane_ctrl(lane_ctrl),
    .err_sticky(err_sticky)
  );

  int checks = 0, failures = 0;
  int m_ph, m_w, m_mf, W, L;
  bit m_st;
  int ncyc = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one link clock with the given inputs, against the reference model
  task automatic step(input bit s, input bit v, input bit e);
    logic [63:0] ew;
    logic [7:0]  ec;
    logic [31:0] x;
    bit lr, fr, last;
    string tag;
    x = ncyc * 32'h9E3779B1 + 32'd1;
    ncyc++;
    sync_req_n = s; in_valid = v; in_err = e;
    in_data = {x ^ 32'h5A5A0F0F, x};
    #1;
    lr = (m_ph == 2) && s;
    fr = s && (m_ph == 2 || (m_ph == 1 && m_mf == 3));
    chk(link_ready == lr, "R6/R8 link_ready", 64'(link_ready), 64'(lr));
    chk(frame_ready == fr, "R7/R8 frame_ready", 64'(frame_ready), 64'(fr));
    chk(mf_start == ((m_w == 0) ? 4'h8 : 4'h0), "R5 mf_start", 64'(mf_start), (m_w == 0) ? 64'h8 : 64'h0);
    ew = '0; ec = '0;
    if (!s || m_ph == 0) tag = "R2 comma word";
    else if (m_ph == 1)  tag = "R3/R4 alignment word";
    else if (!e && v)    tag = "R6 data word";
    else if (e)          tag = "R9 filler word";
    else                 tag = "R10 filler word";
    for (int l = 0; l < LANES; l++) begin
      for (int j = 0; j < 4; j++) begin
        int o, bp;
        logic [7:0] oc;
        bit cf;
        o = m_w * 4 + j;
        bp = 32 * l + 8 * (3 - j);
        cf = 1'b0;
        if (!s || m_ph == 0) begin oc = 8'hBC; cf = 1'b1; end
        else if (m_ph == 1) begin
          if (o == 0)                     begin oc = 8'h1C; cf = 1'b1; end
          else if (o == L - 1)            begin oc = 8'h7C; cf = 1'b1; end
          else if (m_mf == 1 && o == 1)   begin oc = 8'h9C; cf = 1'b1; end
          else oc = 8'(o);
        end else if (v && !e) oc = in_data[bp +: 8];
        else oc = FILL;
        ew[bp +: 8] = oc;
        ec[4 * l + 3 - j] = cf;
      end
    end
    if (lr && e) m_st = 1'b1;
    last = (m_w == W - 1);
    m_w = last ? 0 : m_w + 1;
    if (!s) begin m_ph = 0; m_mf = 0; end
    else if (m_ph == 0) begin if (last) begin m_ph = 1; m_mf = 0; end end
    else if (m_ph == 1) begin if (last) begin if (m_mf == 3) m_ph = 2; else m_mf++; end end
    @(posedge clk);
    @(negedge clk);
    chk(lane_data == ew, tag, lane_data, ew);
    chk(lane_ctrl == ec, tag, 64'(lane_ctrl), 64'(ec));
    chk(err_sticky == m_st, (e && !lr) ? "R11 sticky" : "R9/R10 sticky", 64'(err_sticky), 64'(m_st));
  endtask

  task automatic run_config(input int f, input int k);
    int g;
    frame_octets = 8'(f); mf_frames = 5'(k);
    W = f * k / 4; L = f * k;
    @(negedge clk);
    rst_n = 1'b0; sync_req_n = 1'b0; in_err = 1'b1;
    #2;
    // R1 reset state
    chk(lane_data == {LANES*4{8'hBC}} && lane_ctrl == '1, "R1 reset words", lane_data, {LANES*4{8'hBC}});
    chk(!link_ready && !frame_ready && !err_sticky, "R1 reset flags",
        {61'd0, link_ready, frame_ready, err_sticky}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    m_ph = 0; m_w = 0; m_mf = 0; m_st = 1'b0;
    for (int i = 0; i < 2 * W + 1; i++) step(1'b0, 1'b1, (i == 1)); // R11 err in sync phase
    g = 0;
    while (m_ph != 2 && g < 8 * W + 8) begin step(1'b1, 1'b1, 1'b0); g++; end
    for (int i = 0; i < W + 3; i++) step(1'b1, (i != 2), 1'b0);     // R10 at i==2
    step(1'b0, 1'b1, 1'b1);                                          // R8 drop with R11 err
    for (int i = 0; i < W + 1; i++) step(1'b0, 1'b1, 1'b0);
    g = 0;
    while (!(m_ph == 1 && m_mf == 1) && g < 4 * W + 8) begin step(1'b1, 1'b1, 1'b0); g++; end
    step(1'b0, 1'b1, 1'b0);                                          // R8 drop in alignment
    step(1'b0, 1'b1, 1'b0);
    g = 0;
    while (m_ph != 2 && g < 8 * W + 8) begin step(1'b1, 1'b1, 1'b0); g++; end
    for (int i = 0; i < 2 * W + 4; i++) step(1'b1, (i != 5), (i == 3 || i == 5)); // R9
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    run_config(1, 4);
    run_config(2, 6);
    run_config(3, 4);
    run_config(4, 5);
    run_config(8, 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule